// File: doc/BRIEF.md
# Two-Source External Interrupt Controller

This block turns two external request pins into a single vectored interrupt request for a small processor core. Each source picks one of eight port pins through a select field, applies a polarity choice, and is then sensed either as a level or as an edge. Edge sensing works by sampling. The synchronized line has to stay at a new value for a set number of consecutive clocks before that value counts. A falling (activating) transition that survives this filter sets a pending flag. The flag holds the event until the core takes it.

Requests then pass through a per-source enable and a global enable. They are ranked by a two-level programmable priority, and within one level a fixed order puts source 0 ahead of source 1. A two-entry in-service record, one entry per level, tracks which handlers are running. It blocks any request at the same or a lower level, so only a high-level request can break into a low-level handler. The core acknowledges the presented vector with a one-cycle strobe and marks the end of a handler with a return strobe.

Top module: `xint_ctrl`

## Requirements
- R1: The route register (address 0) holds, per source i, a 3-bit pin index at bits [4i+2:4i] and a polarity bit at bit 4i+3. Polarity 0 makes a low pin active and polarity 1 makes a high pin active.
- R2: In edge mode, a source requests only after its synchronized line has been seen inactive and then active for HOLD consecutive clocks (HOLD = 3 by default). An active pulse shorter than that makes no request.
- R3: A line held active in edge mode makes exactly one request. The source re-arms only after the line has been inactive for HOLD clocks and then goes active again.
- R4: An edge event stays pending while the global enable is off or while a handler blocks it, and it is presented once it is no longer blocked.
- R5: In level mode (mode bit 0), a source requests exactly while its synchronized pin is active and keeps no memory of past activity.
- R6: When both sources are eligible at the same level, source 0 is presented.
- R7: While a handler of a level is in service, no request of that level (or of the low level under a high handler) is presented, whatever its fixed order.
- R8: A source whose priority bit is 1 is high level. A high-level request is presented over a low-level one regardless of source order, and it is presented even while a low-level handler is in service.
- R9: A source is presented only if its enable bit and the global enable are both 1. Source 0 presents vector 0x03 and source 1 presents vector 0x13.
- R10: An acknowledge clears the pending flag of the acknowledged edge-mode source. A new qualified edge of that source in the same clock stays pending.
- R11: The return strobe ends the high-level handler if one is in service, otherwise the low-level one.
- R12: The control register (address 1) holds mode bits at [1:0] (1 = edge), enables at [3:2], priority bits at [5:4] and the global enable at bit 7. Both registers reset to zero, so the request output is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 route, 1 control |
| cfg_wdata | input | 8 | Register write data |
| pins_i | input | NPINS (8) | Raw asynchronous port pins |
| ack_i | input | 1 | Core accepts the presented vector |
| reti_i | input | 1 | Core finished the current handler |
| irq_o | output | 1 | Interrupt request toward the core |
| vec_o | output | 8 | Vector address of the presented source |

## Verification
The delicate coincidence is a qualified edge of a source that lands in the same clock as the core's acknowledge of that source's older event. In that clock the pending flag is both set and cleared. The bench times a second activating transition so that its third stable sample falls exactly on the acknowledge edge. It then issues a return strobe and requires vector 0x03 to reappear, which shows that the new event survived. A behavioural model that is compared every clock also covers acknowledges that coincide with preemption and with configuration writes.

// File: rtl/xint_pkg.sv
// Shared constants for the two-source external interrupt controller.
// Assumes exactly two sources; vector addresses are fixed per source.
package xint_pkg;
    localparam int NSRC  = 2;
    localparam int REG_W = 8;
    localparam int VEC_W = 8;

    // control register bit positions
    localparam int CB_EDGE = 0;
    localparam int CB_EN   = 2;
    localparam int CB_HI   = 4;
    localparam int CB_GLOB = 7;

    // vector address for a source: 0x03, 0x13
    function automatic logic [VEC_W-1:0] vec_for(input int idx);
        return VEC_W'(16 * idx + 3);
    endfunction
endpackage

// File: rtl/xint_sync.sv
// Two-flop synchronizer for a bus of asynchronous pins.
// Assumes pins are independent; resets to all ones (idle for active-low lines).
module xint_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;

    // capture and re-register every pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '1;
            q        <= '1;
        end else begin
            stage1_q <= d;
            q        <= stage1_q;
        end
    end
endmodule

// File: rtl/xint_line.sv
// One request line: pin selection, polarity, sampling filter, edge latch.
// Assumes pins_s is already synchronized. The filter accepts a new line
// value only after HOLD consecutive samples; an accepted activation in edge
// mode sets the pending flag, which the arbiter's take strobe clears.
module xint_line #(
    parameter int NPINS = 8,
    parameter int SELW  = 3,
    parameter int HOLD  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_s,
    input  logic [SELW-1:0]  sel,
    input  logic             act_high,
    input  logic             edge_mode,
    input  logic             take,
    output logic             req
);
    localparam int CNTW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CNTW-1:0] LAST = CNTW'(HOLD - 1);

    logic            active;
    logic            qual_q;
    logic [CNTW-1:0] cnt_q;
    logic            settle;
    logic            pend_q;

    // polarity-corrected view of the selected pin
    always_comb active = act_high ? pins_s[sel] : ~pins_s[sel];

    // the differing value has been seen for HOLD samples
    always_comb settle = (active != qual_q) && (cnt_q == LAST);

    // sampling filter: track the accepted line value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            qual_q <= 1'b0;
            cnt_q  <= '0;
        end else if (active == qual_q) begin
            cnt_q  <= '0;
        end else if (settle) begin
            qual_q <= active;
            cnt_q  <= '0;
        end else begin
            cnt_q  <= cnt_q + CNTW'(1);
        end
    end

    // pending latch: set wins over take, cleared outside edge mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!edge_mode) begin
            pend_q <= 1'b0;
        end else if (settle && active) begin
            pend_q <= 1'b1;
        end else if (take) begin
            pend_q <= 1'b0;
        end
    end

    // request as seen by the arbiter
    always_comb req = edge_mode ? pend_q : active;
endmodule

// File: rtl/xint_arb.sv
// Priority arbiter with a per-level in-service record.
// Assumes req is already gated by enables. High-level requests win first,
// then the lowest index. A running handler blocks its own level and below.
module xint_arb
    import xint_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic [N-1:0]     lvl_hi,
    input  logic             ack,
    input  logic             reti,
    output logic             irq,
    output logic [VEC_W-1:0] vec,
    output logic [N-1:0]     grant
);
    logic         ins_lo_q, ins_hi_q;
    logic         ins_lo_n, ins_hi_n;
    logic [N-1:0] elig, pool;
    logic         found, grant_hi;

    // pick the presented source
    always_comb begin
        elig  = req & ~{N{ins_hi_q}} & (ins_lo_q ? lvl_hi : {N{1'b1}});
        pool  = (|(elig & lvl_hi)) ? (elig & lvl_hi) : elig;
        grant = '0;
        vec   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (pool[i] && !found) begin
                grant[i] = 1'b1;
                vec      = vec_for(i);
                found    = 1'b1;
            end
        end
    end

    always_comb irq      = |grant;
    always_comb grant_hi = |(grant & lvl_hi);

    // next in-service record: pop on return, push on acknowledge
    always_comb begin
        ins_lo_n = ins_lo_q;
        ins_hi_n = ins_hi_q;
        if (reti) begin
            if (ins_hi_q) ins_hi_n = 1'b0;
            else          ins_lo_n = 1'b0;
        end
        if (ack && irq) begin
            if (grant_hi) ins_hi_n = 1'b1;
            else          ins_lo_n = 1'b1;
        end
    end

    // in-service record registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ins_lo_q <= 1'b0;
            ins_hi_q <= 1'b0;
        end else begin
            ins_lo_q <= ins_lo_n;
            ins_hi_q <= ins_hi_n;
        end
    end
endmodule

// File: rtl/xint_ctrl.sv
// Top of the two-source external interrupt controller.
// Holds the route and control registers, synchronizes the pins, runs one
// line per source and arbitrates. Outputs depend on registers only.
module xint_ctrl
    import xint_pkg::*;
#(
    parameter int NPINS = 8,
    parameter int HOLD  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [REG_W-1:0] cfg_wdata,
    input  logic [NPINS-1:0] pins_i,
    input  logic             ack_i,
    input  logic             reti_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o
);
    localparam int SELW = $clog2(NPINS);
    localparam int FLD  = SELW + 1;
    localparam int RW   = NSRC * FLD;

    logic [RW-1:0]    route_q;
    logic [REG_W-1:0] ctrl_q;
    logic [NPINS-1:0] pins_s;
    logic [NSRC-1:0]  line_req, gated_req, lvl_hi, grant, take;

    // register write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= '0;
            ctrl_q  <= '0;
        end else if (cfg_we) begin
            if (cfg_addr) ctrl_q  <= cfg_wdata;
            else          route_q <= cfg_wdata[RW-1:0];
        end
    end

    xint_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pins_i),
        .q     (pins_s)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_line
        xint_line #(.NPINS(NPINS), .SELW(SELW), .HOLD(HOLD)) u_line (
            .clk       (clk),
            .rst_n     (rst_n),
            .pins_s    (pins_s),
            .sel       (route_q[i*FLD +: SELW]),
            .act_high  (route_q[i*FLD + SELW]),
            .edge_mode (ctrl_q[CB_EDGE + i]),
            .take      (take[i]),
            .req       (line_req[i])
        );
        // enable gating and level bit per source
        always_comb gated_req[i] = line_req[i] & ctrl_q[CB_EN + i] & ctrl_q[CB_GLOB];
        always_comb lvl_hi[i]    = ctrl_q[CB_HI + i];
    end

    xint_arb #(.N(NSRC)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (gated_req),
        .lvl_hi (lvl_hi),
        .ack    (ack_i),
        .reti   (reti_i),
        .irq    (irq_o),
        .vec    (vec_o),
        .grant  (grant)
    );

    // acknowledge routed to the granted line
    always_comb take = grant & {NSRC{ack_i}};
endmodule

// File: rtl/xint_chk.sv
// Assertion checker for xint_ctrl, attached by bind below.
// Observes ports and the control register and grant of the top.
module xint_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_o,
    input logic [7:0] vec_o,
    input logic       ack_i,
    input logic [7:0] ctrl_q,
    input logic [1:0] grant
);
    assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ctrl_q[7]);

    assert_vec_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_o == 8'h03 || vec_o == 8'h13));

    assert_single_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_hi_blocks_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && |(grant & ctrl_q[5:4])) |=> !irq_o);

    assert_no_same_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && |(grant & ~ctrl_q[5:4])) |=> (!irq_o || |(grant & ctrl_q[5:4])));
endmodule

bind xint_ctrl xint_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .irq_o  (irq_o),
    .vec_o  (vec_o),
    .ack_i  (ack_i),
    .ctrl_q (ctrl_q),
    .grant  (grant)
);

// File: tb/xint_ctrl_tb_top.sv
// Bench for xint_ctrl: behavioural reference model compared every clock,
// plus directed checks per requirement.
module xint_ctrl_tb_top;
    localparam int HOLD = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_addr = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] pins = 8'hFF;
    logic       ack = 1'b0;
    logic       reti = 1'b0;
    logic       irq;
    logic [7:0] vec;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_tag = "R12";

    always #2 clk = ~clk;

    xint_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pins_i(pins), .ack_i(ack), .reti_i(reti),
        .irq_o(irq), .vec_o(vec)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_s1 = 8'hFF, m_s2 = 8'hFF, m_route = 0, m_ctrl = 0;
    int m_cnt [2];
    bit m_qual[2], m_pend[2];
    bit m_lo, m_hi;

    function automatic bit m_act(int i);
        int s;
        s = (m_route >> (i * 4)) & 7;
        return m_route[i*4+3] ? m_s2[s] : !m_s2[s];
    endfunction

    function automatic int m_pick();
        int best, besthi;
        bit r;
        best = -1; besthi = -1;
        for (int i = 0; i < 2; i++) begin
            r = m_ctrl[7] && m_ctrl[2+i] && (m_ctrl[i] ? m_pend[i] : m_act(i));
            if (r && !m_hi && (!m_lo || m_ctrl[4+i])) begin
                if (m_ctrl[4+i] && besthi < 0) besthi = i;
                if (best < 0) best = i;
            end
        end
        return (besthi >= 0) ? besthi : best;
    endfunction

    always @(posedge clk) begin : model_upd
        int g;
        bit a, setp;
        if (!rst_n) begin
            m_s1 = 8'hFF; m_s2 = 8'hFF; m_route = 0; m_ctrl = 0;
            m_lo = 0; m_hi = 0;
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 0; m_qual[i] = 0; m_pend[i] = 0;
            end
        end else begin
            g = m_pick();
            if (reti) begin
                if (m_hi) m_hi = 0; else m_lo = 0;
            end
            if (ack && g >= 0) begin
                if (m_ctrl[4+g]) m_hi = 1; else m_lo = 1;
            end
            for (int i = 0; i < 2; i++) begin
                a = m_act(i);
                setp = 0;
                if (a == m_qual[i]) m_cnt[i] = 0;
                else if (m_cnt[i] == HOLD - 1) begin
                    m_qual[i] = a; m_cnt[i] = 0; setp = a;
                end else m_cnt[i]++;
                if (!m_ctrl[i]) m_pend[i] = 0;
                else if (setp) m_pend[i] = 1;
                else if (ack && g == i) m_pend[i] = 0;
            end
            m_s2 = m_s1;
            m_s1 = pins;
            if (cfg_we) begin
                if (cfg_addr) m_ctrl = cfg_wdata; else m_route = cfg_wdata;
            end
        end
    end

    // compare against the model every clock
    always @(posedge clk) begin : model_cmp
        int g;
        logic [7:0] ev;
        #1;
        if (!done) begin
            g = m_pick();
            ev = (g < 0) ? 8'h00 : ((g == 0) ? 8'h03 : 8'h13);
            n_checks++;
            if (irq !== (g >= 0) || (g >= 0 && vec !== ev)) begin
                n_fail++;
                $display("FAIL %s model: irq=%0b vec=%02h expected irq=%0b vec=%02h",
                         cur_tag, irq, vec, (g >= 0), ev);
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(bit a, logic [7:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic do_ack();
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0;
    endtask

    task automatic do_reti();
        @(negedge clk); reti = 1;
        @(negedge clk); reti = 0;
    endtask

    task automatic expect_out(string tag, bit eirq, logic [7:0] evec);
        n_checks++;
        if (irq !== eirq || (eirq && vec !== evec)) begin
            n_fail++;
            $display("FAIL %s directed: irq=%0b vec=%02h expected irq=%0b vec=%02h",
                     tag, irq, vec, eirq, evec);
        end
    endtask

    // full activating pulse on one pin, long enough to qualify both ways
    task automatic pulse_pin(int idx);
        @(negedge clk); pins[idx] = 0;
        tick(8);
        pins[idx] = 1;
        tick(8);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        tick(4);
        rst_n = 1;
        tick(2);
        cur_tag = "R12";
        expect_out("R12", 0, 8'h00);

        // route: src0 pin5 active-low, src1 pin7 active-low
        wr(0, 8'h75);
        wr(1, 8'h8F);      // edge both, enable both, global, low level
        tick(8);

        cur_tag = "R2";
        @(negedge clk); pins[5] = 0;
        tick(2); pins[5] = 1;
        tick(10);
        expect_out("R2", 0, 8'h00);

        @(negedge clk); pins[5] = 0;
        tick(8);
        expect_out("R2", 1, 8'h03);
        cur_tag = "R10";
        do_ack();
        expect_out("R10", 0, 8'h00);
        do_reti();
        cur_tag = "R3";
        tick(20);
        expect_out("R3", 0, 8'h00);
        @(negedge clk); pins[5] = 1;
        tick(8);
        pulse_pin(5);
        expect_out("R3", 1, 8'h03);
        do_ack(); do_reti();

        cur_tag = "R4";
        wr(1, 8'h0F);
        pulse_pin(7);
        expect_out("R4", 0, 8'h00);
        wr(1, 8'h8F);
        tick(1);
        expect_out("R4", 1, 8'h13);
        expect_out("R9", 1, 8'h13);
        do_ack(); do_reti();

        cur_tag = "R6";
        @(negedge clk); pins[5] = 0; pins[7] = 0;
        tick(8); pins[5] = 1; pins[7] = 1;
        tick(8);
        expect_out("R6", 1, 8'h03);
        do_ack();
        expect_out("R7", 0, 8'h00);
        do_reti();
        expect_out("R4", 1, 8'h13);
        do_ack(); do_reti();

        cur_tag = "R7";
        pulse_pin(7);
        do_ack();
        pulse_pin(5);
        expect_out("R7", 0, 8'h00);
        do_reti();
        expect_out("R7", 1, 8'h03);
        do_ack(); do_reti();

        cur_tag = "R8";
        wr(1, 8'hAF);      // source 1 high level
        @(negedge clk); pins[5] = 0; pins[7] = 0;
        tick(8); pins[5] = 1; pins[7] = 1;
        tick(8);
        expect_out("R8", 1, 8'h13);
        do_ack();
        expect_out("R8", 0, 8'h00);
        do_reti();
        expect_out("R8", 1, 8'h03);
        do_ack();          // low handler running
        pulse_pin(7);
        expect_out("R8", 1, 8'h13);
        do_ack();          // high handler preempts
        cur_tag = "R11";
        pulse_pin(5);
        do_reti();         // pops high, low still running
        expect_out("R11", 0, 8'h00);
        do_reti();         // pops low
        expect_out("R11", 1, 8'h03);
        do_ack(); do_reti();

        cur_tag = "R10";
        wr(1, 8'h8F);
        pulse_pin(5);
        expect_out("R10", 1, 8'h03);
        @(negedge clk); pins[5] = 0;
        tick(3);
        do_ack();          // acknowledge lands on the new qualification edge
        do_reti();
        expect_out("R10", 1, 8'h03);
        do_ack(); do_reti();
        @(negedge clk); pins[5] = 1;
        tick(8);

        cur_tag = "R5";
        wr(1, 8'h8C);      // level both
        expect_out("R5", 0, 8'h00);
        @(negedge clk); pins[5] = 0;
        tick(3);
        expect_out("R5", 1, 8'h03);
        @(negedge clk); pins[5] = 1;
        tick(3);
        expect_out("R5", 0, 8'h00);

        cur_tag = "R1";
        wr(0, 8'h7A);      // src0 pin2 active-high
        tick(3);
        expect_out("R1", 1, 8'h03);
        @(negedge clk); pins[2] = 0;
        tick(3);
        expect_out("R1", 0, 8'h00);
        @(negedge clk); pins[2] = 1;
        wr(0, 8'h75);
        tick(3);

        cur_tag = "R9";
        wr(1, 8'h88);      // level, only source 1 enabled
        @(negedge clk); pins[5] = 0;
        tick(4);
        expect_out("R9", 0, 8'h00);
        @(negedge clk); pins[7] = 0;
        tick(3);
        expect_out("R9", 1, 8'h13);
        @(negedge clk); pins[5] = 1; pins[7] = 1;
        tick(4);
        expect_out("R9", 0, 8'h00);

        tick(4);
        finish_run();
    end
endmodule